// File: doc/BRIEF.md
# XOR-Detector Digital Phase-Locked Loop

This block is an all-digital phase-locked loop for a resonant inverter controller. It takes a square-wave reference that has been squared from an analog signal. It produces a divided feedback square wave that follows the reference in frequency and settles a quarter period ahead of it. The feedback is the signal that drives the switching stage. A second output carries the raw oscillator pulse train, and a flag reports when the loop has settled.

The loop has four parts. An exclusive-OR detector compares the synchronised reference with the feedback. A modulo-K up/down counter filters the detector output. It emits a one-cycle overflow pulse, which retards the oscillator, or a one-cycle underflow pulse, which advances it. The oscillator is a pulse-slot generator that nominally fires every second clock, and each correction moves the next pulse one clock later or earlier. A divide-by-N counter turns the pulse train into the feedback. The filter clock (M times the centre frequency) and the oscillator clock (2N times the centre frequency) are the same frequency because M = 2N. One clock `clk` at 2N times the centre frequency therefore serves both. N and K must be powers of two, and K must be at least 8. The defaults are N = 16 (so M = 32) and K = 8, which is M/4, the setting that gives the smallest ripple.

Top module: `xor_adpll`

## Requirements
- R1: The reference passes through two clock flops before the detector, so a reference edge reaches the detector two clocks after it is driven.
- R2: The filter counter counts up in each clock where reference and feedback differ and counts down otherwise, modulo K. A step from K-1 to 0 gives a one-cycle overflow pulse, and a step from 0 to K-1 gives a one-cycle underflow pulse.
- R3: The oscillator output `id_out` is high for one clock per pulse and, left alone, pulses every second clock. An overflow delays the next pulse by one clock, and an underflow brings it one clock earlier. The two never pulse back to back unless an advance is pending. Every feedback period holds exactly N pulses.
- R4: `fb_out` is the oscillator pulse count divided by N, with a 50 % pulse split. It changes only on a clock that carries a pulse. With the reference held low, the average feedback period stays within 2N ± 2 clocks.
- R5: For a reference period between 2N-3 and 2N+3 clocks, the loop captures the reference. Once settled, 16 feedback periods span 16 reference periods within ±4 clocks.
- R6: At lock with a 2N-clock reference, the feedback rising edge leads the synchronised reference rising edge by N/2 clocks (90 degrees). At the ports this is N/2-2 clocks before the reference rise, ±3 clocks.
- R7: `locked` is set only after LOCK_PERIODS (default 16) consecutive feedback periods, each with a net overflow-minus-underflow count of -1, 0 or +1. Any other period clears the count. The flag changes only at a feedback rising edge.
- R8: With a steady frequency offset that needs more than one net correction per period (a reference of 2N±3 clocks), `locked` stays low.
- R9: While `rst_n` is low, `fb_out`, `id_out` and `locked` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock at 2N times the centre frequency |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave, asynchronous to clk |
| id_out | output | 1 | Oscillator pulse train, one clock high per pulse |
| fb_out | output | 1 | Divided feedback square wave that drives the switching stage |
| locked | output | 1 | High after LOCK_PERIODS balanced feedback periods |

## Verification
The embedded properties check the cycle-level mechanics on every clock. These are the wrap rule of the filter counter, the spacing of oscillator pulses, feedback changes only on a pulse, and the lock flag moving only at a feedback rising edge. The loop-level behaviour only shows up over many periods, so only the bench scenarios can show it. That behaviour covers frequency capture at several offsets, the quarter-period lead at lock, the lock flag rising after the required run and staying low under a persistent offset, and the free-running period with no reference.

// File: rtl/xor_adpll.sv
module xor_adpll #(
  parameter int N            = 16,
  parameter int K            = 8,
  parameter int LOCK_PERIODS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic id_out,
  output logic fb_out,
  output logic locked
);
  localparam int NW = $clog2(N);
  localparam int KW = $clog2(K);
  localparam int LW = $clog2(LOCK_PERIODS + 1);
  localparam int IW = $clog2(3 * N / K + 2) + 2;

  logic [1:0]    sync_q;
  logic          ref_s, det;
  logic [KW-1:0] kcnt;
  logic          carry, borrow;
  logic          ph, adv_p, ret_p;
  logic          adv_set, ret_set, adv_now, ret_now, tick;
  logic [NW-1:0] dcnt;
  logic          fb_rise, bal_ok;
  logic [IW-1:0] bal;
  logic [LW-1:0] lcnt;

  assign ref_s = sync_q[1];
  assign det   = ref_s ^ fb_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ref_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kcnt <= '0; carry <= 1'b0; borrow <= 1'b0;
    end else begin
      carry  <= 1'b0;
      borrow <= 1'b0;
      if (det) begin
        if (kcnt == KW'(K - 1)) begin kcnt <= '0; carry <= 1'b1; end
        else kcnt <= kcnt + 1'b1;
      end else begin
        if (kcnt == '0) begin kcnt <= KW'(K - 1); borrow <= 1'b1; end
        else kcnt <= kcnt - 1'b1;
      end
    end

  // a_r2 checks: wraps happen only at the counter ends
  a_r2_carry_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (kcnt == '0 && $past(kcnt) == KW'(K - 1)));
  a_r2_borrow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    borrow |-> (kcnt == KW'(K - 1) && $past(kcnt) == '0));

  // overflow retards, underflow advances; opposite requests cancel
  assign adv_set = adv_p | borrow;
  assign ret_set = ret_p | carry;
  assign adv_now = adv_set & ~ret_set;
  assign ret_now = ret_set & ~adv_set;
  assign tick    = ph ? ~ret_now : adv_now;
  assign id_out  = tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= 1'b0; adv_p <= 1'b0; ret_p <= 1'b0;
    end else begin
      ph    <= ~tick;
      adv_p <= adv_now & ph;
      ret_p <= ret_now & ~ph;
    end

  a_r3_pulse_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !adv_set) |=> (!tick || adv_p || borrow));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    dcnt <= '0;
    else if (tick) dcnt <= dcnt + 1'b1;

  assign fb_out  = dcnt[NW-1];
  assign fb_rise = tick && (dcnt == NW'(N / 2 - 1));

  a_r4_fb_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fb_out));

  assign bal_ok = (bal == '0) || (bal == IW'(1)) || (bal == {IW{1'b1}});

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bal <= '0; lcnt <= '0;
    end else if (fb_rise) begin
      bal <= IW'(carry) - IW'(borrow);
      if (!bal_ok)                          lcnt <= '0;
      else if (lcnt != LW'(LOCK_PERIODS))   lcnt <= lcnt + 1'b1;
    end else begin
      bal <= bal + IW'(carry) - IW'(borrow);
    end

  assign locked = (lcnt == LW'(LOCK_PERIODS));

  a_r7_lock_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(fb_rise));
endmodule

// File: tb/test_xor_adpll.sv
module test_xor_adpll;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int K = 8;

  logic clk = 1'b0, rst_n = 1'b0, ref_in = 1'b0;
  logic id_out, fb_out, locked;

  xor_adpll #(.N(N), .K(K), .LOCK_PERIODS(16)) i_xor_adpll (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .id_out(id_out), .fb_out(fb_out), .locked(locked));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int cyc = 0, rises = 0, last_rise = 0, last_lead = 0;
  int tick_acc = 0, ticks_per = 0;
  int ref_per = 0, rcnt = 0;
  logic fb_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (fb_out && !fb_prev) begin
      rises = rises + 1; last_rise = cyc;
      ticks_per = tick_acc; tick_acc = 0;
    end
    fb_prev = fb_out;
    if (id_out) tick_acc = tick_acc + 1;
    if (ref_per > 0) begin
      rcnt = rcnt + 1;
      if (rcnt >= ref_per) rcnt = 0;
      ref_in = (rcnt < ref_per / 2);
      if (rcnt == 0) last_lead = cyc - last_rise;
    end else ref_in = 1'b0;
  end

  function automatic int exp_lead();
    return N / 2 - 2;
  endfunction
  function automatic bit exp_locked(int p);
    return p == 2 * N;
  endfunction
  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_rises(int n);
    int target = rises + n;
    while (rises < target) begin @(negedge clk); #1; end
  endtask

  task automatic track(int p, string req);
    int start, total;
    wait_rises(1);
    start = last_rise;
    wait_rises(16);
    total = last_rise - start;
    check(iabs(total - 16 * p) <= 4, req, total, 16 * p);
  endtask

  task automatic set_ref(int p);
    @(negedge clk); #1;
    rcnt = $urandom_range(0, p - 1);
    ref_per = p;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int start, total;
    void'($urandom(32'd4242));
    // R9 reset state
    repeat (4) @(negedge clk);
    #1;
    check(fb_out == 1'b0, "R9 fb_out", fb_out, 0);
    check(id_out == 1'b0, "R9 id_out", id_out, 0);
    check(locked == 1'b0, "R9 locked", locked, 0);
    rst_n = 1'b1;

    // R4 free run with reference low; R3 pulses per period
    wait_rises(8);
    start = last_rise;
    wait_rises(16);
    total = last_rise - start;
    check(iabs(total - 16 * 2 * N) <= 32, "R4 free-run period", total, 16 * 2 * N);
    check(ticks_per == N, "R3 pulses per period", ticks_per, N);

    // lock at the centre frequency, random phase
    @(negedge clk); rst_n = 1'b0;
    set_ref(2 * N);
    @(negedge clk); rst_n = 1'b1;
    wait_rises(10);
    check(locked == 1'b0, "R7 early lock", locked, 0);
    wait_rises(60);
    check(locked == 1'b1, "R7 lock asserted", locked, 1);
    check(iabs(last_lead - exp_lead()) <= 3, "R6 R1 lead at lock", last_lead, exp_lead());
    track(2 * N, "R5 track centre");
    check(ticks_per == N, "R3 pulses per period locked", ticks_per, N);

    // capture limits with offset too large for the lock flag
    set_ref(2 * N + 3);
    wait_rises(60);
    track(2 * N + 3, "R5 track slow");
    check(locked == 1'b0, "R8 slow offset", locked, 0);
    set_ref(2 * N - 3);
    wait_rises(60);
    track(2 * N - 3, "R5 track fast");
    check(locked == 1'b0, "R8 fast offset", locked, 0);

    // random periods and phases
    for (int i = 0; i < 6; i++) begin
      int p;
      p = $urandom_range(2 * N - 2, 2 * N + 2);
      set_ref(p);
      wait_rises(60);
      track(p, "R5 random period");
      if (exp_locked(p)) begin
        check(locked == 1'b1, "R7 random lock", locked, 1);
        check(iabs(last_lead - exp_lead()) <= 3, "R6 random lead", last_lead, exp_lead());
      end
    end

    // reset while locked
    set_ref(2 * N);
    wait_rises(60);
    check(locked == 1'b1, "R7 relock", locked, 1);
    @(negedge clk); rst_n = 1'b0;
    #1;
    check(locked == 1'b0, "R9 reset clears lock", locked, 0);
    check(fb_out == 1'b0, "R9 reset clears fb", fb_out, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule